// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the bus-write strobes that a host sends to a parallel NOR flash. For each strobe it takes the address and the data byte. It follows the unlock handshake and the command cycles that come after it, and for every command that completes it raises a registered one-cycle pulse. The pulse carries a 3-bit command code, and for program and block-add commands it also carries the captured address and data. The program/erase controller downstream acts on these pulses. That controller reports back through a `busy` input. While `busy` is high the decoder holds its sequence state and its timer, and the only command it accepts is an erase suspend, and only while a block erase is running.

The decoder has two persistent flags. The unlock-bypass flag shortens a program to two writes. The erase-suspended flag records that a block erase is on hold, waiting for a resume.

The sequence states are:
- `ST_IDLE`
- `ST_UNLK1`: first unlock write seen.
- `ST_UNLK2`: second unlock write seen; the command write comes next.
- `ST_PROG`: waiting for the program address and data.
- `ST_ER_UNLK0` / `ST_ER_UNLK1`: the second unlock pair of an erase.
- `ST_ER_SEL`: chip erase or block erase is chosen here.
- `ST_BLK_COLLECT`: gathering block addresses until the timeout.
- `ST_BYP_PROG`: bypass program, waiting for the address and data.
- `ST_BYP_EXIT`: bypass exit, waiting for 00.

The transitions are:
- `ST_IDLE`→`ST_UNLK1` on AA@555.
- `ST_UNLK1`→`ST_UNLK2` on 55@2AA.
- `ST_UNLK2`→`ST_PROG` on A0@555.
- `ST_UNLK2`→`ST_ER_UNLK0` on 80@555.
- `ST_UNLK2`→`ST_IDLE` on F0, 90 or 20 @555. The 20 write also sets the bypass flag.
- `ST_PROG`→`ST_IDLE` on any write.
- `ST_ER_UNLK0`→`ST_ER_UNLK1` on AA@555.
- `ST_ER_UNLK1`→`ST_ER_SEL` on 55@2AA.
- `ST_ER_SEL`→`ST_IDLE` on 10@555.
- `ST_ER_SEL`→`ST_BLK_COLLECT` on 30 at any address.
- `ST_BLK_COLLECT` stays in place on 30.
- `ST_BLK_COLLECT`→`ST_IDLE` on any other write or on timeout.
- In bypass mode, `ST_IDLE`→`ST_BYP_PROG` on A0, and `ST_IDLE`→`ST_BYP_EXIT` on 90.
- `ST_BYP_PROG`→`ST_IDLE` on any write.
- `ST_BYP_EXIT`→`ST_IDLE` on any write.
- In any state, a write that does not match the expected one returns the decoder to `ST_IDLE`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid`, `bypass_mode` and `erase_suspended` are all 0.
- R2: Command matching compares only address bits [10:0]. The higher address bits have no effect on matching. A write whose low 11 bits differ from 555 does not count as a 555 write.
- R3: In `ST_IDLE`, outside bypass mode, a write of F0 to any address gives a pulse with code 0 (read/reset). F0@555 as the third write after the unlock pair also gives code 0.
- R4: The writes AA@555, 55@2AA, 90@555 give a pulse with code 1 (auto-select).
- R5: The writes AA@555, 55@2AA, A0@555 followed by one more write give a pulse with code 2 (program). `cmd_addr` and `cmd_data` equal the address and data of that last write.
- R6: A write that does not match the next expected write of a sequence returns the decoder to idle and gives no pulse. Later writes are decoded from idle.
- R7: The writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 give a pulse with code 3 (chip erase).
- R8: When the sixth write of an erase sequence is 30 at any address, the decoder gives a pulse with code 4 (block add), with `cmd_addr` set to that address. In collection, each further write of 30 gives another code 4 pulse and restarts the timer. Exactly TIMEOUT cycles after the last code 4 pulse, a pulse with code 5 (block erase start) follows.
- R9: During collection, a write of any value other than 30 abandons the collection, and no code 5 pulse follows.
- R10: AA@555, 55@2AA, 20@555 sets `bypass_mode`. In bypass mode, A0 at any address followed by one more write gives a code 2 pulse carrying that second write's address and data. In bypass mode, writes of other values (including F0) in idle give no pulse and leave the flag set.
- R11: In bypass mode, 90 at any address followed by 00 clears `bypass_mode` and gives a code 0 pulse.
- R12: While `busy` is high, writes give no pulse, and both the sequence state and the timer hold. The one exception is a write of B0 while the last started erase was a block erase that has not yet ended: this gives a pulse with code 6 (suspend) and sets `erase_suspended`. After a chip erase, B0 is ignored.
- R13: While `erase_suspended` is set and `busy` is low, the full program sequence is accepted. A write of 30 to any address in idle gives a pulse with code 7 (resume) and clears `erase_suspended`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus-write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Controller is running a program or erase |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 3 | Command code (0 reset, 1 auto-select, 2 program, 3 chip erase, 4 block add, 5 block erase start, 6 suspend, 7 resume) |
| cmd_addr | output | ADDR_W | Captured address for program and block add |
| cmd_data | output | 8 | Captured data for program |
| bypass_mode | output | 1 | Unlock-bypass mode is active |
| erase_suspended | output | 1 | A block erase is suspended |

## Verification
The checker tests several properties on every cycle:
- A chip-erase pulse is always preceded by 10@555.
- A program pulse carries exactly the address and data of the previous write.
- While busy, the only pulse that can appear is a suspend.
- The suspend and resume pulses always agree with the suspended flag.
- The bypass flag rises only after a 20 write and falls only after a 00 write.

Other behaviour needs the bench's scenarios to show it: decoding of whole multi-write sequences, the exact cycle distance between the last block add and the erase start, abandonment on broken sequences, and whether the upper address bits are ignored.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_PROG,
        ST_ER_UNLK0,
        ST_ER_UNLK1,
        ST_ER_SEL,
        ST_BLK_COLLECT,
        ST_BYP_PROG,
        ST_BYP_EXIT
    } seq_state_e;

    typedef enum logic [2:0] {
        CMD_RESET      = 3'd0,
        CMD_AUTOSEL    = 3'd1,
        CMD_PROGRAM    = 3'd2,
        CMD_CHIP_ERASE = 3'd3,
        CMD_BLK_ADD    = 3'd4,
        CMD_BLK_GO     = 3'd5,
        CMD_SUSPEND    = 3'd6,
        CMD_RESUME     = 3'd7
    } cmd_e;

    localparam logic [7:0] D_UNLOCK_A = 8'hAA;
    localparam logic [7:0] D_UNLOCK_B = 8'h55;
    localparam logic [7:0] D_RESET    = 8'hF0;
    localparam logic [7:0] D_AUTOSEL  = 8'h90;
    localparam logic [7:0] D_PROGRAM  = 8'hA0;
    localparam logic [7:0] D_BYPASS   = 8'h20;
    localparam logic [7:0] D_ERASE    = 8'h80;
    localparam logic [7:0] D_CHIP     = 8'h10;
    localparam logic [7:0] D_BLOCK    = 8'h30;
    localparam logic [7:0] D_SUSPEND  = 8'hB0;
    localparam logic [7:0] D_BYP_EXIT = 8'h00;

endpackage

// File: rtl/flash_addr_match.sv
module flash_addr_match #(
    parameter int CMP_W = 11
) (
    input  logic [CMP_W-1:0] low_addr,
    output logic             at_first,
    output logic             at_second
);
    localparam logic [CMP_W-1:0] FIRST_ADDR  = CMP_W'(11'h555);
    localparam logic [CMP_W-1:0] SECOND_ADDR = CMP_W'(11'h2AA);

    assign at_first  = (low_addr == FIRST_ADDR);
    assign at_second = (low_addr == SECOND_ADDR);
endmodule

// File: rtl/flash_blk_timer.sv
module flash_blk_timer #(
    parameter int TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int CMP_W   = 11,
    parameter int TIMEOUT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              bypass_mode,
    output logic              erase_suspended
);
    seq_state_e        state_q, state_d;
    logic              at_first, at_second;
    logic              tmr_load, tmr_run, tmr_expired;
    logic              busy_q, blkrun_q, blkrun_d;
    logic              valid_d, byp_d, susp_d;
    cmd_e              code_d;
    logic [ADDR_W-1:0] addr_d;
    logic [7:0]        data_d;

    flash_addr_match #(.CMP_W(CMP_W)) match_i (
        .low_addr  (wr_addr[CMP_W-1:0]),
        .at_first  (at_first),
        .at_second (at_second)
    );

    assign tmr_run = (state_q == ST_BLK_COLLECT) && !busy;

    flash_blk_timer #(.TIMEOUT(TIMEOUT)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            busy_q   <= 1'b0;
            blkrun_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            busy_q   <= busy;
            blkrun_q <= blkrun_d;
        end
    end

    // next-state and next-output decode
    always_comb begin
        state_d  = state_q;
        valid_d  = 1'b0;
        code_d   = CMD_RESET;
        addr_d   = wr_addr;
        data_d   = wr_data;
        byp_d    = bypass_mode;
        susp_d   = erase_suspended;
        blkrun_d = blkrun_q;
        tmr_load = 1'b0;
        if (busy) begin
            if (wr_en && wr_data == D_SUSPEND && blkrun_q && !erase_suspended) begin
                valid_d = 1'b1;
                code_d  = CMD_SUSPEND;
                susp_d  = 1'b1;
            end
        end else begin
            if (busy_q && !erase_suspended) begin
                blkrun_d = 1'b0;
            end
            unique case (state_q)
                ST_IDLE: if (wr_en) begin
                    if (bypass_mode) begin
                        if (wr_data == D_PROGRAM)      state_d = ST_BYP_PROG;
                        else if (wr_data == D_AUTOSEL) state_d = ST_BYP_EXIT;
                    end else if (wr_data == D_RESET) begin
                        valid_d = 1'b1;
                        code_d  = CMD_RESET;
                    end else if (wr_data == D_UNLOCK_A && at_first) begin
                        state_d = ST_UNLK1;
                    end else if (wr_data == D_BLOCK && erase_suspended) begin
                        valid_d = 1'b1;
                        code_d  = CMD_RESUME;
                        susp_d  = 1'b0;
                    end
                end
                ST_UNLK1: if (wr_en) begin
                    state_d = (wr_data == D_UNLOCK_B && at_second) ? ST_UNLK2 : ST_IDLE;
                end
                ST_UNLK2: if (wr_en) begin
                    state_d = ST_IDLE;
                    if (at_first) begin
                        if (wr_data == D_RESET) begin
                            valid_d = 1'b1;
                            code_d  = CMD_RESET;
                        end else if (wr_data == D_AUTOSEL) begin
                            valid_d = 1'b1;
                            code_d  = CMD_AUTOSEL;
                        end else if (wr_data == D_PROGRAM) begin
                            state_d = ST_PROG;
                        end else if (wr_data == D_BYPASS) begin
                            byp_d = 1'b1;
                        end else if (wr_data == D_ERASE) begin
                            state_d = ST_ER_UNLK0;
                        end
                    end
                end
                ST_PROG, ST_BYP_PROG: if (wr_en) begin
                    valid_d = 1'b1;
                    code_d  = CMD_PROGRAM;
                    state_d = ST_IDLE;
                end
                ST_ER_UNLK0: if (wr_en) begin
                    state_d = (wr_data == D_UNLOCK_A && at_first) ? ST_ER_UNLK1 : ST_IDLE;
                end
                ST_ER_UNLK1: if (wr_en) begin
                    state_d = (wr_data == D_UNLOCK_B && at_second) ? ST_ER_SEL : ST_IDLE;
                end
                ST_ER_SEL: if (wr_en) begin
                    state_d = ST_IDLE;
                    if (wr_data == D_CHIP && at_first) begin
                        valid_d  = 1'b1;
                        code_d   = CMD_CHIP_ERASE;
                        blkrun_d = 1'b0;
                    end else if (wr_data == D_BLOCK) begin
                        valid_d  = 1'b1;
                        code_d   = CMD_BLK_ADD;
                        tmr_load = 1'b1;
                        state_d  = ST_BLK_COLLECT;
                    end
                end
                ST_BLK_COLLECT: begin
                    if (wr_en) begin
                        if (wr_data == D_BLOCK) begin
                            valid_d  = 1'b1;
                            code_d   = CMD_BLK_ADD;
                            tmr_load = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else if (tmr_expired) begin
                        valid_d  = 1'b1;
                        code_d   = CMD_BLK_GO;
                        addr_d   = '0;
                        data_d   = '0;
                        blkrun_d = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
                ST_BYP_EXIT: if (wr_en) begin
                    state_d = ST_IDLE;
                    if (wr_data == D_BYP_EXIT) begin
                        byp_d   = 1'b0;
                        valid_d = 1'b1;
                        code_d  = CMD_RESET;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid       <= 1'b0;
            cmd_code        <= '0;
            cmd_addr        <= '0;
            cmd_data        <= '0;
            bypass_mode     <= 1'b0;
            erase_suspended <= 1'b0;
        end else begin
            cmd_valid       <= valid_d;
            cmd_code        <= code_d;
            cmd_addr        <= valid_d ? addr_d : cmd_addr;
            cmd_data        <= valid_d ? data_d : cmd_data;
            bypass_mode     <= byp_d;
            erase_suspended <= susp_d;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int ADDR_W = 19,
    parameter int CMP_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              busy,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [7:0]        cmd_data,
    input logic              bypass_mode,
    input logic              erase_suspended
);
    // R7
    chip_erase_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd3) |->
            ($past(wr_en) && $past(wr_data) == 8'h10 && $past(wr_addr[CMP_W-1:0]) == CMP_W'(11'h555)));

    // R5
    prog_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd2) |->
            ($past(wr_en) && cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data)));

    // R12
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!cmd_valid || cmd_code == 3'd6));

    // R12
    suspend_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd6) |-> (erase_suspended && !$past(erase_suspended)));

    // R13
    resume_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd7) |-> (!erase_suspended && $past(erase_suspended)));

    // R10
    bypass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass_mode) |-> ($past(wr_en) && $past(wr_data) == 8'h20));

    // R11
    bypass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bypass_mode) |-> ($past(wr_en) && $past(wr_data) == 8'h00 && cmd_valid && cmd_code == 3'd0));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .bypass_mode(bypass_mode), .erase_suspended(erase_suspended)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
    localparam int AW = 19;
    localparam int TO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy = 1'b0;
    logic          cmd_valid;
    logic [2:0]    cmd_code;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_data;
    logic          bypass_mode;
    logic          erase_suspended;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .CMP_W(11), .TIMEOUT(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .bypass_mode(bypass_mode), .erase_suspended(erase_suspended)
    );

    typedef struct {
        logic [2:0]    code;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        bit            cmp_ad;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    int   cyc = 0;
    int   t_add = 0;
    int   t_go = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_cmd(input logic [2:0] c, input logic [AW-1:0] a,
                              input logic [7:0] d, input bit cmp, input string tag);
        exp_t e;
        e.code = c; e.addr = a; e.data = d; e.cmp_ad = cmp; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(19'h00555, 8'hAA);
        wr(19'h002AA, 8'h55);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected items as pulses appear
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (cmd_code == 3'd4) t_add = cyc;
            if (cmd_code == 3'd5) t_go = cyc;
            if (exp_q.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL unexpected pulse: actual code=%0d expected none", cmd_code);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " code"}, int'(cmd_code), int'(e.code));
                if (e.cmp_ad) begin
                    check({e.tag, " addr"}, int'(cmd_addr), int'(e.addr));
                    check({e.tag, " data"}, int'(cmd_data), int'(e.data));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cmd_valid", int'(cmd_valid), 0);
        check("R1 bypass_mode", int'(bypass_mode), 0);
        check("R1 erase_suspended", int'(erase_suspended), 0);
        rst_n = 1'b1;
        idle(2);

        // R3 single-write reset, any address
        expect_cmd(3'd0, 19'h7FFFF, 8'hF0, 1'b1, "R3");
        wr(19'h7FFFF, 8'hF0);
        // R3 reset via unlock sequence
        expect_cmd(3'd0, 19'h00555, 8'hF0, 1'b0, "R3 seq");
        unlock(); wr(19'h00555, 8'hF0);

        // R2 + R4: upper bits set, low bits match
        expect_cmd(3'd1, 19'h78555, 8'h90, 1'b0, "R2 R4");
        wr(19'h78555, 8'hAA); wr(19'h502AA, 8'h55); wr(19'h40555, 8'h90);
        // R2: low bits 455 are not 555, no unlock
        wr(19'h00455, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
        idle(2);
        check("R2 no pulse", exp_q.size(), 0);

        // R5 program
        expect_cmd(3'd2, 19'h12345, 8'h5A, 1'b1, "R5");
        unlock(); wr(19'h00555, 8'hA0); wr(19'h12345, 8'h5A);

        // R6 broken sequence
        wr(19'h00555, 8'hAA); wr(19'h002AB, 8'h55); wr(19'h00555, 8'hA0); wr(19'h01111, 8'h77);
        idle(2);
        check("R6 no pulse", exp_q.size(), 0);
        expect_cmd(3'd1, 19'h0, 8'h0, 1'b0, "R6 recover");
        unlock(); wr(19'h00555, 8'h90);

        // R7 chip erase, then busy ignores everything (R12)
        expect_cmd(3'd3, 19'h0, 8'h0, 1'b0, "R7");
        unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10);
        @(negedge clk); busy = 1'b1;
        wr(19'h00000, 8'hF0); wr(19'h00555, 8'hAA); wr(19'h00000, 8'hB0);
        @(negedge clk); busy = 1'b0;
        idle(2);
        check("R12 chip-erase busy ignore", exp_q.size(), 0);
        check("R12 no suspend after chip erase", int'(erase_suspended), 0);
        // state held while busy: AA during busy did not start a sequence
        wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
        idle(2);
        check("R12 state held", exp_q.size(), 0);

        // R8 block erase with two blocks and timeout
        expect_cmd(3'd4, 19'h10000, 8'h30, 1'b1, "R8 add1");
        expect_cmd(3'd4, 19'h20000, 8'h30, 1'b1, "R8 add2");
        expect_cmd(3'd5, 19'h0, 8'h0, 1'b0, "R8 go");
        unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h10000, 8'h30);
        idle(5);
        wr(19'h20000, 8'h30);
        idle(TO + 4);
        check("R8 timeout distance", t_go - t_add, TO);

        // R12 suspend during block erase, R13 program while suspended, resume
        @(negedge clk); busy = 1'b1;
        idle(2);
        expect_cmd(3'd6, 19'h0, 8'h0, 1'b0, "R12 suspend");
        wr(19'h03333, 8'hB0);
        check("R12 suspended flag", int'(erase_suspended), 1);
        @(negedge clk); busy = 1'b0;
        expect_cmd(3'd2, 19'h0ABCD, 8'hC3, 1'b1, "R13 prog in suspend");
        unlock(); wr(19'h00555, 8'hA0); wr(19'h0ABCD, 8'hC3);
        expect_cmd(3'd7, 19'h0, 8'h0, 1'b0, "R13 resume");
        wr(19'h04444, 8'h30);
        check("R13 flag cleared", int'(erase_suspended), 0);
        @(negedge clk); busy = 1'b1;
        idle(3);
        busy = 1'b0;
        idle(2);
        busy = 1'b1;
        wr(19'h00000, 8'hB0);
        @(negedge clk); busy = 1'b0;
        idle(2);
        check("R12 B0 after erase end", int'(erase_suspended), 0);

        // R9 collection abandoned
        expect_cmd(3'd4, 19'h30000, 8'h30, 1'b1, "R9 add");
        unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h30000, 8'h30);
        wr(19'h00000, 8'h55);
        idle(TO + 4);
        check("R9 no start", exp_q.size(), 0);

        // R10 bypass mode
        unlock(); wr(19'h00555, 8'h20);
        check("R10 bypass set", int'(bypass_mode), 1);
        expect_cmd(3'd2, 19'h05678, 8'h99, 1'b1, "R10 bypass prog");
        wr(19'h7F000, 8'hA0); wr(19'h05678, 8'h99);
        wr(19'h00000, 8'hF0);
        idle(2);
        check("R10 F0 ignored", exp_q.size(), 0);
        check("R10 still bypass", int'(bypass_mode), 1);

        // R11 bypass exit
        expect_cmd(3'd0, 19'h0, 8'h0, 1'b0, "R11 exit");
        wr(19'h01234, 8'h90); wr(19'h00000, 8'h00);
        check("R11 bypass cleared", int'(bypass_mode), 0);

        idle(4);
        check("final queue empty", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule